// File: doc/BRIEF.md
# Sub-second timer with write-completion tracking

This block is a two-stage time counter: a sub-second counter that wraps at a configurable terminal count and a seconds counter that advances on each wrap. Each counter has a compare value. When the counter reaches its compare value, an interrupt flag sets. A control register enables each counter and each interrupt output.

All registers sit on a simple single-cycle register bus in the fast clock domain. A register write is not applied at once. It stays pending until a fixed number of slow-domain ticks (the `slow_tick` strobe) have passed, which models the transfer into a slow counting domain. While a write is pending, the status register shows a busy flag for that register. If software writes the same register again before the pending write completes, a sticky error flag sets. Any write to the status register clears that error flag. The interrupt-clear register works through the same pending-write mechanism.

Top module: `rtc_subsec_timer`

## Requirements
- R1: After reset, every readable register (offsets 0x00 to 0x18) reads 0, and `irq_sub` and `irq_sec` are low.
- R2: A write to offset 0x00 (sub-second count), 0x04 (seconds count), 0x08 (sub-second compare), 0x0C (seconds compare) or 0x10 (control) takes effect on the WR_LAT-th `slow_tick` after the write. Until then the register keeps reading its old value.
- R3: Status bits 4 to 10 are busy flags. In that order they cover: sub-second count, seconds count, sub-second compare, seconds compare, control, sub-second clear and seconds clear. Status bit 3 is the OR of all seven. A busy flag sets in the cycle after the write and drops in the same cycle that the write takes effect.
- R4: Control bit 0 enables the sub-second counter and control bit 1 enables the seconds counter. While an enable is 0, its counter holds its value across ticks.
- R5: A write to a register whose busy flag is set sets status bit 2, which stays set. The rejected data is discarded, and the earlier pending value is the one applied.
- R6: A write of any data to offset 0x14 clears status bit 2.
- R7: On each tick with counting enabled, the sub-second counter increments. At SUB_TERM it wraps to 0, and that wrap increments the seconds counter when control bit 1 is set.
- R8: Status bit 0 sets on a tick where the sub-second counter advances to its compare value. Status bit 1 sets on a tick where the seconds counter advances to its compare value.
- R9: Writing 1 to bit 0 of offset 0x18 clears status bit 0, and writing 1 to bit 1 clears status bit 1. Each clear takes effect WR_LAT ticks after the write. A set in the same cycle wins over the clear.
- R10: `irq_sub` equals status bit 0 AND control bit 2. `irq_sec` equals status bit 1 AND control bit 3.
- R11: Offset 0x18 and unmapped offsets read 0. The control register reads back its 4 bits, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe marking each slow-domain tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write byte offset |
| bus_wdata | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq_sub | output | 1 | Sub-second compare interrupt |
| irq_sec | output | 1 | Seconds compare interrupt |

## Verification
A lost or stuck pending-write countdown shows up at the ports within WR_LAT ticks: either the busy bit never drops, or the new value appears one tick early or late. The bench therefore reads both the status word and the target register at each tick boundary. A flag or enable bit in the wrong state shows up on the interrupt pins in the very next cycle. A wrong wrap or compare shows up within one tick of the counter reaching SUB_TERM or the compare value. The bench steps the ticks one at a time across those points.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NSLOT  = 7;
    localparam int SL_SUB  = 0;
    localparam int SL_SEC  = 1;
    localparam int SL_ASUB = 2;
    localparam int SL_ASEC = 3;
    localparam int SL_CTRL = 4;
    localparam int SL_CSUB = 5;
    localparam int SL_CSEC = 6;

    localparam logic [7:0] OFF_SUB  = 8'h00;
    localparam logic [7:0] OFF_SEC  = 8'h04;
    localparam logic [7:0] OFF_ASUB = 8'h08;
    localparam logic [7:0] OFF_ASEC = 8'h0C;
    localparam logic [7:0] OFF_CTRL = 8'h10;
    localparam logic [7:0] OFF_STAT = 8'h14;
    localparam logic [7:0] OFF_CLR  = 8'h18;

    // bit 0 = cnt_sub_en ... bit 3 = irq_sec_en
    typedef struct packed {
        logic irq_sec_en;
        logic irq_sub_en;
        logic cnt_sec_en;
        logic cnt_sub_en;
    } ctrl_t;
endpackage

// File: rtl/rtc_wr_slot.sv
module rtc_wr_slot #(
    parameter int DATA_W = 32,
    parameter int WR_LAT = 3,
    localparam int CNT_W = $clog2(WR_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              issue,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              clash,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        done  = s_q.busy && tick && (s_q.left == CNT_W'(1));
        clash = issue && s_q.busy;
        if (done) begin
            s_d.busy = 1'b0;
        end else if (s_q.busy && tick) begin
            s_d.left = s_q.left - CNT_W'(1);
        end
        if (issue && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.left = CNT_W'(WR_LAT);
            s_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign data = s_q.data;
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int SUB_W    = 15,
    parameter int SEC_W    = 32,
    parameter int SUB_TERM = 32767
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NSLOT-1:0] commit,
    input  logic [SUB_W-1:0] ld_sub,
    input  logic [SEC_W-1:0] ld_sec,
    input  logic [SUB_W-1:0] ld_asub,
    input  logic [SEC_W-1:0] ld_asec,
    input  ctrl_t            ld_ctrl,
    output logic [SUB_W-1:0] sub_cnt,
    output logic [SEC_W-1:0] sec_cnt,
    output logic [SUB_W-1:0] alm_sub,
    output logic [SEC_W-1:0] alm_sec,
    output ctrl_t            ctrl,
    output logic [1:0]       flags
);
    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] asub;
        logic [SEC_W-1:0] asec;
        ctrl_t            ctrl;
        logic [1:0]       flg;
    } core_t;

    core_t c_d, c_q;
    logic sub_adv, sub_wrap, sec_adv;
    logic [SUB_W-1:0] sub_nx;
    logic [SEC_W-1:0] sec_nx;

    always_comb begin
        c_d      = c_q;
        sub_adv  = tick && c_q.ctrl.cnt_sub_en;
        sub_wrap = sub_adv && (c_q.sub == SUB_W'(SUB_TERM));
        sec_adv  = sub_wrap && c_q.ctrl.cnt_sec_en;
        sub_nx   = sub_wrap ? '0 : c_q.sub + SUB_W'(1);
        sec_nx   = c_q.sec + SEC_W'(1);

        if (sub_adv) c_d.sub = sub_nx;
        if (sec_adv) c_d.sec = sec_nx;

        if (commit[SL_CSUB]) c_d.flg[0] = 1'b0;
        if (commit[SL_CSEC]) c_d.flg[1] = 1'b0;
        if (sub_adv && (sub_nx == c_q.asub)) c_d.flg[0] = 1'b1;
        if (sec_adv && (sec_nx == c_q.asec)) c_d.flg[1] = 1'b1;

        if (commit[SL_SUB])  c_d.sub  = ld_sub;
        if (commit[SL_SEC])  c_d.sec  = ld_sec;
        if (commit[SL_ASUB]) c_d.asub = ld_asub;
        if (commit[SL_ASEC]) c_d.asec = ld_asec;
        if (commit[SL_CTRL]) c_d.ctrl = ld_ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sub_cnt = c_q.sub;
    assign sec_cnt = c_q.sec;
    assign alm_sub = c_q.asub;
    assign alm_sec = c_q.asec;
    assign ctrl    = c_q.ctrl;
    assign flags   = c_q.flg;
endmodule

// File: rtl/rtc_subsec_timer.sv
module rtc_subsec_timer
    import rtc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SUB_W    = 15,
    parameter int SEC_W    = 32,
    parameter int SUB_TERM = 32767,
    parameter int WR_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_sub,
    output logic              irq_sec
);
    logic [NSLOT-1:0] issue, busy, done, clash;
    logic [31:0]      slot_data [NSLOT];
    logic             err_d, err_q;
    logic             stat_wr;
    logic [SUB_W-1:0] sub_cnt, alm_sub;
    logic [SEC_W-1:0] sec_cnt, alm_sec;
    ctrl_t            ctrl;
    logic [1:0]       flags;
    logic [31:0]      status;

    always_comb begin
        issue          = '0;
        issue[SL_SUB]  = bus_we && (bus_addr == ADDR_W'(OFF_SUB));
        issue[SL_SEC]  = bus_we && (bus_addr == ADDR_W'(OFF_SEC));
        issue[SL_ASUB] = bus_we && (bus_addr == ADDR_W'(OFF_ASUB));
        issue[SL_ASEC] = bus_we && (bus_addr == ADDR_W'(OFF_ASEC));
        issue[SL_CTRL] = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
        issue[SL_CSUB] = bus_we && (bus_addr == ADDR_W'(OFF_CLR)) && bus_wdata[0];
        issue[SL_CSEC] = bus_we && (bus_addr == ADDR_W'(OFF_CLR)) && bus_wdata[1];
        stat_wr        = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        rtc_wr_slot #(.DATA_W(32), .WR_LAT(WR_LAT)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (slow_tick),
            .issue (issue[i]),
            .wdata (bus_wdata),
            .busy  (busy[i]),
            .done  (done[i]),
            .clash (clash[i]),
            .data  (slot_data[i])
        );
    end

    rtc_time_core #(.SUB_W(SUB_W), .SEC_W(SEC_W), .SUB_TERM(SUB_TERM)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (slow_tick),
        .commit  (done),
        .ld_sub  (slot_data[SL_SUB][SUB_W-1:0]),
        .ld_sec  (slot_data[SL_SEC][SEC_W-1:0]),
        .ld_asub (slot_data[SL_ASUB][SUB_W-1:0]),
        .ld_asec (slot_data[SL_ASEC][SEC_W-1:0]),
        .ld_ctrl (ctrl_t'(slot_data[SL_CTRL][3:0])),
        .sub_cnt (sub_cnt),
        .sec_cnt (sec_cnt),
        .alm_sub (alm_sub),
        .alm_sec (alm_sec),
        .ctrl    (ctrl),
        .flags   (flags)
    );

    always_comb begin
        err_d = err_q;
        if (|clash) err_d = 1'b1;
        if (stat_wr) err_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign status = {21'b0, busy, |busy, err_q, flags};

    always_comb begin
        case (rd_addr)
            ADDR_W'(OFF_SUB):  rd_data = 32'(sub_cnt);
            ADDR_W'(OFF_SEC):  rd_data = 32'(sec_cnt);
            ADDR_W'(OFF_ASUB): rd_data = 32'(alm_sub);
            ADDR_W'(OFF_ASEC): rd_data = 32'(alm_sec);
            ADDR_W'(OFF_CTRL): rd_data = 32'(ctrl);
            ADDR_W'(OFF_STAT): rd_data = status;
            default:           rd_data = '0;
        endcase
    end

    assign irq_sub = flags[0] && ctrl.irq_sub_en;
    assign irq_sec = flags[1] && ctrl.irq_sec_en;
endmodule

// File: rtl/rtc_subsec_timer_chk.sv
module rtc_subsec_timer_chk #(
    parameter int SUB_W    = 15,
    parameter int SUB_TERM = 32767
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_tick,
    input logic             stat_wr,
    input logic             err_q,
    input logic [6:0]       clash,
    input logic [6:0]       busy,
    input logic [6:0]       done,
    input logic [SUB_W-1:0] sub_cnt,
    input logic [3:0]       ctrl_bits,
    input logic [1:0]       flags,
    input logic             irq_sub,
    input logic             irq_sec
);
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !stat_wr) |=> err_q);

    assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clash && !stat_wr) |=> err_q);

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> !err_q);

    assert_busy_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] && !slow_tick) |=> busy[0]);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[0] && !done[0]) |=> $stable(sub_cnt));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && ctrl_bits[0] && !done[0] && sub_cnt == SUB_W'(SUB_TERM)) |=> (sub_cnt == '0));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sub |-> (ctrl_bits[2] && flags[0])) and (irq_sec |-> (ctrl_bits[3] && flags[1])));
endmodule

bind rtc_subsec_timer rtc_subsec_timer_chk #(.SUB_W(SUB_W), .SUB_TERM(SUB_TERM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .stat_wr   (stat_wr),
    .err_q     (err_q),
    .clash     (clash),
    .busy      (busy),
    .done      (done),
    .sub_cnt   (sub_cnt),
    .ctrl_bits (ctrl),
    .flags     (flags),
    .irq_sub   (irq_sub),
    .irq_sec   (irq_sec)
);

// File: tb/tb_rtc_subsec_timer.sv
module tb_rtc_subsec_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_sub, irq_sec;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    rtc_subsec_timer #(.ADDR_W(8), .SUB_W(15), .SEC_W(32), .SUB_TERM(4), .WR_LAT(2)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_sub(irq_sub), .irq_sec(irq_sec)
    );

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                if (!it.is_irq) rd_addr = it.addr;
                #1;
                got = it.is_irq ? {30'b0, irq_sub, irq_sec} : rd_data;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: addr=%h got=%h exp=%h", it.tag, it.addr, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic exp_irq(input logic [1:0] e, input string tag);
        item_t it;
        it.is_irq = 1; it.addr = 8'hFF; it.exp = {30'b0, e}; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a <= 8'h18; a += 4) exp_reg(8'(a), 32'h0, "R1 reset reg");
        exp_irq(2'b00, "R1 reset irq");

        // R2/R3 write latency and busy
        wr(8'h00, 32'd3);
        exp_reg(8'h14, 32'h18, "R3 busy sub");
        exp_reg(8'h00, 32'd0, "R2 old value while busy");
        tk(1);
        exp_reg(8'h00, 32'd0, "R2 one tick not applied");
        exp_reg(8'h14, 32'h18, "R3 still busy");
        tk(1);
        exp_reg(8'h00, 32'd3, "R2 applied; R4 held while disabled");
        exp_reg(8'h14, 32'h0, "R3 busy dropped");

        // R5 collision, R6 clear
        wr(8'h00, 32'd1);
        wr(8'h00, 32'd2);
        exp_reg(8'h14, 32'h1C, "R5 error set");
        tk(2);
        exp_reg(8'h00, 32'd1, "R5 second write discarded");
        exp_reg(8'h14, 32'h04, "R5 error sticky");
        wr(8'h14, 32'h0);
        exp_reg(8'h14, 32'h0, "R6 error cleared");

        // alarms and control
        wr(8'h08, 32'd2);
        wr(8'h0C, 32'd1);
        tk(2);
        exp_reg(8'h08, 32'd2, "R2 sub compare");
        exp_reg(8'h0C, 32'd1, "R2 sec compare");
        wr(8'h10, 32'hFF);
        tk(2);
        exp_reg(8'h10, 32'hF, "R11 control width");
        exp_reg(8'h00, 32'd1, "R4 no count on enabling tick");
        tk(1);
        exp_reg(8'h00, 32'd2, "R7 count");
        exp_reg(8'h14, 32'h1, "R8 sub flag");
        exp_irq(2'b10, "R10 irq sub");
        tk(3);
        exp_reg(8'h00, 32'd0, "R7 wrap");
        exp_reg(8'h04, 32'd1, "R7 sec increment");
        exp_reg(8'h14, 32'h3, "R8 sec flag");
        exp_irq(2'b11, "R10 both irq");

        // stop counting, clear sub flag
        wr(8'h10, 32'hC);
        tk(2);
        exp_reg(8'h00, 32'd2, "R4 counted before stop");
        wr(8'h18, 32'h1);
        exp_reg(8'h14, 32'h20B, "R3 clear busy");
        tk(1);
        exp_reg(8'h14, 32'h20B, "R9 clear pending");
        tk(1);
        exp_reg(8'h14, 32'h2, "R9 sub flag cleared");
        exp_irq(2'b01, "R9 irq sub dropped");
        tk(2);
        exp_reg(8'h00, 32'd2, "R4 held");

        // R10 enable gating
        wr(8'h10, 32'h4);
        tk(2);
        exp_irq(2'b00, "R10 sec irq masked");
        exp_reg(8'h14, 32'h2, "R10 flag remains");
        wr(8'h18, 32'h2);
        tk(2);
        exp_reg(8'h14, 32'h0, "R9 sec flag cleared");

        // R3 multiple busy, seconds load, R11 read
        wr(8'h08, 32'd7);
        wr(8'h10, 32'h0);
        exp_reg(8'h14, 32'h148, "R3 two busy");
        wr(8'h04, 32'h1234);
        tk(2);
        exp_reg(8'h04, 32'h1234, "R2 seconds load");
        exp_reg(8'h14, 32'h0, "R3 all idle");
        exp_reg(8'h18, 32'h0, "R11 clear reads zero");
        exp_reg(8'h40, 32'h0, "R11 unmapped");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule